// File: doc/BRIEF.md
# Masked Packed-Equality Mask Generator

This block compares two packed vectors element by element and returns a compact result mask that holds one bit per element. It does not return a full-width vector. The elements can be bytes, 16-bit words or 32-bit doublewords. The active vector length can be 128, 256 or 512 bits. A writemask chooses which lanes take part. A lane that is switched off always gives a zero result bit, so only zeroing masking is supported. When the operand is 32-bit and the second source is tagged as coming from memory, a broadcast request compares every lane of the first source against the low 32 bits of the second source.

The execution pipeline uses this block as a one-stage compare unit. The issue logic presents both sources and the control fields together with `in_valid`. The mask appears on `mask_out` one clock later and stays there until the next valid request. When a broadcast is asked for with byte or word elements, the request is ignored and a sticky flag is set. That flag stays high until reset.

Top module: `cmpmask_gen`

## Requirements
- R1: After reset, `mask_out` is all zero and `illegal_flag` is 0.
- R2: `elem_sz` selects the element width: 2'b00 gives 8 bits, 2'b01 gives 16 bits, 2'b10 gives 32 bits. Element j occupies bits [j*W+W-1 : j*W] of each source. Mask bit j is 1 exactly when element j of `src_a` equals element j of `src_b` and lane j is enabled.
- R3: `vlen` selects the active length: 2'b00 gives 128 bits, 2'b01 gives 256 bits, 2'b10 gives 512 bits. The active element count is the length divided by W. Every mask bit at or above that count is 0.
- R4: When `no_wmask` is 0, lane j is enabled only if `wmask[j]` is 1, and a disabled lane yields 0. When `no_wmask` is 1, `wmask` has no effect.
- R5: With 32-bit elements, when `bcast` and `b_is_mem` are both 1, every active lane of `src_a` is compared with `src_b[31:0]`. When `bcast` is 1 and `b_is_mem` is 0, the compare stays lane by lane.
- R6: With 8-bit or 16-bit elements, `bcast` has no effect on the mask. In that case a valid request with `bcast` = 1 sets `illegal_flag`, and the flag stays 1 until reset.
- R7: If `vlen` is 2'b11 or `elem_sz` is 2'b11, the mask is all zero.
- R8: `mask_out` updates on the clock edge that samples `in_valid` = 1. It holds its value while `in_valid` is 0, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| src_a | input | 512 | First packed source |
| src_b | input | 512 | Second packed source |
| elem_sz | input | 2 | Element width code |
| vlen | input | 2 | Vector length code |
| wmask | input | 64 | Per-lane writemask |
| no_wmask | input | 1 | Ignore the writemask, enabling all lanes |
| bcast | input | 1 | Broadcast request |
| b_is_mem | input | 1 | Second source is a memory operand |
| mask_out | output | 64 | Registered result mask |
| illegal_flag | output | 1 | Sticky flag: broadcast requested with 8-bit or 16-bit elements |

## Verification
Two cases can land in the same request. In the first, a broadcast request with byte or word elements must raise the sticky flag while the mask is still computed lane by lane and still gated by the writemask. In the second, writemask bits set above the active element count must be cut off by the length limit, not let through by the mask. Random requests mix broadcast, memory tag, writemask, length and width codes freely, and a share of the lanes is forced to match so that the compare returns ones. Directed requests set up the exact overlaps. The mask and the flag are both compared against a bench model after every request.

// File: rtl/cmpm_pkg.sv
package cmpm_pkg;

   typedef enum logic [1:0] {
      ESZ_8  = 2'b00,
      ESZ_16 = 2'b01,
      ESZ_32 = 2'b10,
      ESZ_NA = 2'b11
   } esz_t;

   typedef enum logic [1:0] {
      VL_128 = 2'b00,
      VL_256 = 2'b01,
      VL_512 = 2'b10,
      VL_NA  = 2'b11
   } vl_t;

   // number of active elements for a given data width, size and length code
   function automatic int unsigned active_lanes(input int unsigned data_w,
                                                input logic [1:0] esz,
                                                input logic [1:0] vl);
      int unsigned bits;
      if (esz == ESZ_NA || vl == VL_NA) return 0;
      bits = (data_w / 4) << vl;
      return bits >> (3 + esz);
   endfunction

endpackage

// File: rtl/cmpm_eq_bank.sv
module cmpm_eq_bank #(
   parameter int DATA_W   = 512,
   parameter int ELEM_W   = 8,
   parameter bit BCAST_OK = 1'b0,
   localparam int N_EL    = DATA_W / ELEM_W
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              bcast_en,
   output logic [N_EL-1:0]   eq
);

   if (DATA_W % ELEM_W != 0) begin : g_bad_w
      $error("cmpm_eq_bank: DATA_W must be a multiple of ELEM_W");
   end

   if (BCAST_OK) begin : g_bcast
      logic [ELEM_W-1:0] b_scalar;
      assign b_scalar = b[ELEM_W-1:0];
      for (genvar j = 0; j < N_EL; j++) begin : g_lane
         assign eq[j] = (a[j*ELEM_W +: ELEM_W] ==
                         (bcast_en ? b_scalar : b[j*ELEM_W +: ELEM_W]));
      end
   end else begin : g_plain
      logic unused_bc;
      assign unused_bc = bcast_en;
      for (genvar j = 0; j < N_EL; j++) begin : g_lane
         assign eq[j] = (a[j*ELEM_W +: ELEM_W] == b[j*ELEM_W +: ELEM_W]);
      end
   end

endmodule

// File: rtl/cmpm_lane_gate.sv
module cmpm_lane_gate
   import cmpm_pkg::*;
#(
   parameter int DATA_W = 512,
   parameter int MASK_W = 64
) (
   input  logic [1:0]        esz,
   input  logic [1:0]        vl,
   input  logic [MASK_W-1:0] wmask,
   input  logic              no_wmask,
   output logic [MASK_W-1:0] lane_en
);

   int unsigned n_act;

   always_comb begin
      n_act = active_lanes(DATA_W, esz, vl);
      for (int j = 0; j < MASK_W; j++) begin
         lane_en[j] = (32'(j) < n_act) && (no_wmask || wmask[j]);
      end
   end

endmodule

// File: rtl/cmpmask_gen.sv
module cmpmask_gen
   import cmpm_pkg::*;
#(
   parameter int DATA_W = 512,
   parameter int MASK_W = 64,
   localparam int N8    = DATA_W / 8,
   localparam int N16   = DATA_W / 16,
   localparam int N32   = DATA_W / 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [1:0]        elem_sz,
   input  logic [1:0]        vlen,
   input  logic [MASK_W-1:0] wmask,
   input  logic              no_wmask,
   input  logic              bcast,
   input  logic              b_is_mem,
   output logic [MASK_W-1:0] mask_out,
   output logic              illegal_flag
);

   if (DATA_W % 128 != 0) begin : g_chk_data
      $error("cmpmask_gen: DATA_W must be a multiple of 128");
   end
   if (MASK_W < N8) begin : g_chk_mask
      $error("cmpmask_gen: MASK_W too narrow for byte lanes");
   end

   logic [N8-1:0]     eq8;
   logic [N16-1:0]    eq16;
   logic [N32-1:0]    eq32;
   logic              dw_bcast;
   logic [MASK_W-1:0] raw_eq;
   logic [MASK_W-1:0] lane_en;
   logic              bad_bcast;

   assign dw_bcast  = bcast & b_is_mem;
   assign bad_bcast = bcast & ((elem_sz == ESZ_8) | (elem_sz == ESZ_16));

   cmpm_eq_bank #(.DATA_W(DATA_W), .ELEM_W(8), .BCAST_OK(1'b0)) u_eq8 (
      .a(src_a), .b(src_b), .bcast_en(1'b0), .eq(eq8));

   cmpm_eq_bank #(.DATA_W(DATA_W), .ELEM_W(16), .BCAST_OK(1'b0)) u_eq16 (
      .a(src_a), .b(src_b), .bcast_en(1'b0), .eq(eq16));

   cmpm_eq_bank #(.DATA_W(DATA_W), .ELEM_W(32), .BCAST_OK(1'b1)) u_eq32 (
      .a(src_a), .b(src_b), .bcast_en(dw_bcast), .eq(eq32));

   cmpm_lane_gate #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_gate (
      .esz(elem_sz), .vl(vlen), .wmask(wmask), .no_wmask(no_wmask),
      .lane_en(lane_en));

   always_comb begin
      raw_eq = '0;
      unique case (elem_sz)
         ESZ_8:   raw_eq[N8-1:0]  = eq8;
         ESZ_16:  raw_eq[N16-1:0] = eq16;
         ESZ_32:  raw_eq[N32-1:0] = eq32;
         default: raw_eq = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_out     <= '0;
         illegal_flag <= 1'b0;
      end else if (in_valid) begin
         mask_out <= raw_eq & lane_en;
         if (bad_bcast) illegal_flag <= 1'b1;
      end
   end

endmodule

// File: rtl/cmpm_chk.sv
module cmpm_chk
   import cmpm_pkg::*;
#(
   parameter int DATA_W = 512,
   parameter int MASK_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        elem_sz,
   input logic [1:0]        vlen,
   input logic [MASK_W-1:0] wmask,
   input logic              no_wmask,
   input logic              bcast,
   input logic [MASK_W-1:0] mask_out,
   input logic              illegal_flag
);

   logic [MASK_W-1:0] len_lim;
   int unsigned       n_lim;

   always_comb begin
      n_lim = active_lanes(DATA_W, elem_sz, vlen);
      for (int j = 0; j < MASK_W; j++) len_lim[j] = (32'(j) < n_lim);
   end

   assert_len_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((mask_out & ~$past(len_lim)) == '0));

   assert_zero_masking_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !no_wmask) |=> ((mask_out & ~$past(wmask)) == '0));

   assert_flag_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && bcast && (elem_sz == ESZ_8 || elem_sz == ESZ_16)) |=> illegal_flag);

   assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_flag |=> illegal_flag);

   assert_bad_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (vlen == VL_NA || elem_sz == ESZ_NA)) |=> (mask_out == '0));

   assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(mask_out));

endmodule

bind cmpmask_gen cmpm_chk #(.DATA_W(DATA_W), .MASK_W(MASK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .elem_sz(elem_sz),
   .vlen(vlen), .wmask(wmask), .no_wmask(no_wmask), .bcast(bcast),
   .mask_out(mask_out), .illegal_flag(illegal_flag));

// File: tb/sim_cmpmask_gen.sv
`timescale 1ns/1ps
module sim_cmpmask_gen;

   localparam int DW = 512;
   localparam int MW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] src_a = '0;
   logic [DW-1:0] src_b = '0;
   logic [1:0]    elem_sz = 2'b00;
   logic [1:0]    vlen = 2'b00;
   logic [MW-1:0] wmask = '0;
   logic          no_wmask = 1'b0;
   logic          bcast = 1'b0;
   logic          b_is_mem = 1'b0;
   logic [MW-1:0] mask_out;
   logic          illegal_flag;

   int  n_run  = 0;
   int  n_fail = 0;
   bit  exp_ill = 1'b0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   cmpmask_gen #(.DATA_W(DW), .MASK_W(MW)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_a(src_a),
      .src_b(src_b), .elem_sz(elem_sz), .vlen(vlen), .wmask(wmask),
      .no_wmask(no_wmask), .bcast(bcast), .b_is_mem(b_is_mem),
      .mask_out(mask_out), .illegal_flag(illegal_flag));

   function automatic logic [MW-1:0] model(input logic [DW-1:0] a, input logic [DW-1:0] b,
                                           input logic [1:0] es, input logic [1:0] vl,
                                           input logic [MW-1:0] wm, input logic nw,
                                           input logic bc, input logic mem);
      logic [MW-1:0] r = '0;
      int ew, vb, n;
      logic [31:0] em, ea, eb;
      ew = (es == 2'd0) ? 8 : (es == 2'd1) ? 16 : (es == 2'd2) ? 32 : 0;
      vb = (vl == 2'd0) ? 128 : (vl == 2'd1) ? 256 : (vl == 2'd2) ? 512 : 0;
      if (ew == 0 || vb == 0) return '0;
      n  = vb / ew;
      em = (ew == 32) ? 32'hFFFF_FFFF : ((32'd1 << ew) - 32'd1);
      for (int j = 0; j < n; j++) begin
         ea = 32'(a >> (j*ew)) & em;
         eb = (bc && mem && ew == 32) ? b[31:0] : (32'(b >> (j*ew)) & em);
         r[j] = (ea == eb) && (nw || wm[j]);
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [MW-1:0] got, input logic [MW-1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic req(input string tag, input logic [DW-1:0] a, input logic [DW-1:0] b,
                      input logic [1:0] es, input logic [1:0] vl, input logic [MW-1:0] wm,
                      input logic nw, input logic bc, input logic mem);
      logic [MW-1:0] e;
      @(negedge clk);
      src_a = a; src_b = b; elem_sz = es; vlen = vl; wmask = wm;
      no_wmask = nw; bcast = bc; b_is_mem = mem; in_valid = 1'b1;
      e = model(a, b, es, vl, wm, nw, bc, mem);
      if (bc && (es == 2'd0 || es == 2'd1)) exp_ill = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check({tag, " mask"}, mask_out, e);
      check({tag, " flag"}, {63'd0, illegal_flag}, {63'd0, exp_ill});
   endtask

   function automatic logic [DW-1:0] rnd_vec();
      logic [DW-1:0] v;
      for (int k = 0; k < DW/32; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [MW-1:0] rnd_mask();
      return {$urandom, $urandom};
   endfunction

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic [DW-1:0] a, b;
      logic [MW-1:0] held;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 reset mask", mask_out, '0);
      check("R1 reset flag", {63'd0, illegal_flag}, 64'd0);
      rst_n = 1'b1;

      a = rnd_vec();
      // R2 all bytes equal, full length, no writemask
      req("R2 bytes equal", a, a, 2'd0, 2'd2, '0, 1'b1, 1'b0, 1'b0);
      // R2 words differ in every second lane
      b = a;
      for (int j = 0; j < 32; j += 2) b[j*16] = ~b[j*16];
      req("R2 words alt", a, b, 2'd1, 2'd2, '0, 1'b1, 1'b0, 1'b0);
      // R3 writemask above active count is clipped (dword, 128 -> 4 lanes)
      req("R3 dword 128", a, a, 2'd2, 2'd0, '1, 1'b0, 1'b0, 1'b0);
      req("R3 byte 256", a, a, 2'd0, 2'd1, '1, 1'b0, 1'b0, 1'b0);
      // R4 zeroing by writemask
      req("R4 wmask", a, a, 2'd0, 2'd2, 64'hA5A5_0F0F_1234_8001, 1'b0, 1'b0, 1'b0);
      req("R4 no_wmask", a, a, 2'd1, 2'd1, 64'd0, 1'b1, 1'b0, 1'b0);
      // R5 dword broadcast from memory
      b = rnd_vec();
      for (int j = 0; j < 16; j += 3) a[j*32 +: 32] = b[31:0];
      req("R5 bcast mem", a, b, 2'd2, 2'd2, '0, 1'b1, 1'b1, 1'b1);
      req("R5 bcast reg", a, b, 2'd2, 2'd2, '0, 1'b1, 1'b1, 1'b0);
      // R6 broadcast ignored for words, flag set, combined with writemask
      a = rnd_vec();
      b = a; b[15:0] = ~b[15:0];
      req("R6 word bcast", a, b, 2'd1, 2'd2, 64'h0000_0000_F0F0_FFFF, 1'b0, 1'b1, 1'b1);
      req("R6 sticky", a, a, 2'd2, 2'd0, '0, 1'b1, 1'b0, 1'b0);
      // R7 reserved codes
      req("R7 vlen 11", a, a, 2'd0, 2'd3, '0, 1'b1, 1'b0, 1'b0);
      req("R7 esz 11", a, a, 2'd3, 2'd2, '0, 1'b1, 1'b0, 1'b0);

      // R8 hold while idle
      req("R8 load", a, a, 2'd0, 2'd2, '0, 1'b1, 1'b0, 1'b0);
      held = mask_out;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         src_b = rnd_vec(); elem_sz = 2'($urandom); vlen = 2'($urandom);
         wmask = rnd_mask(); no_wmask = 1'($urandom);
      end
      @(negedge clk);
      check("R8 hold", mask_out, held);

      // random mix (R2..R7)
      for (int t = 0; t < 400; t++) begin
         logic [1:0] es, vl;
         a = rnd_vec();
         b = a;
         for (int k = 0; k < DW/8; k++)
            if ($urandom % 4 == 0) b[k*8 +: 8] = 8'($urandom);
         if ($urandom % 3 == 0)
            for (int j = 0; j < 16; j++) if ($urandom % 2 == 0) a[j*32 +: 32] = b[31:0];
         es = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
         vl = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
         req("R2 random", a, b, es, vl, rnd_mask(), 1'($urandom % 2),
             1'($urandom % 2), 1'($urandom % 2));
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule